// File: doc/BRIEF.md
# Aliased Single/Double Floating-Point Register File

This block holds the floating-point architectural registers of a core. One physical storage array can be seen in two ways. In the narrow view it is 32 registers of 32 bits. In the wide view it is 16 registers of 64 bits. Each wide register n is made of narrow registers 2n and 2n+1, so a value written through either view shows up at once through the other.

There are two read ports and one main write port. Each of them carries a view-select bit and a register index. A separate 32-bit transfer path lets the integer core copy a core register into one narrow register. It also lets the core read one narrow register back. Reads are purely combinational. All writes take effect on the rising clock edge.

Top module: `fpr_alias_regfile`

## Requirements
- R1: After the asynchronous active-low reset, every narrow register reads as zero.
- R2: With the view bit at 0 (narrow), a read port returns narrow register `idx` (all 5 index bits are used) on data bits 31:0, with bits 63:32 equal to zero.
- R3: With the view bit at 1 (wide), a read port returns wide register n = `idx[3:0]`. Bits 31:0 come from narrow register 2n and bits 63:32 from narrow register 2n+1. `idx[4]` is ignored.
- R4: A wide write (view bit 1) stores `wr_data[31:0]` into narrow register 2n and `wr_data[63:32]` into 2n+1 on the same clock edge.
- R5: A narrow write (view bit 0) stores `wr_data[31:0]` into narrow register `wr_idx` only. Its even/odd partner keeps its value, and `wr_data[63:32]` is ignored.
- R6: A transfer write stores `xfer_wr_data` into narrow register `xfer_wr_idx` on the clock edge.
- R7: The transfer read output shows narrow register `xfer_rd_idx` combinationally.
- R8: When the main write and the transfer write hit the same narrow register in one cycle, the main write's value is stored. Writes to different registers in the same cycle both take effect.
- R9: A read of a register that is being written in the same cycle returns the old value. The new value appears only after the edge.
- R10: For a wide write, `wr_idx[4]` has no effect on which pair is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_dbl | input | 1 | Read port 0 view: 0 narrow, 1 wide |
| rd0_idx | input | 5 | Read port 0 register index |
| rd0_data | output | 64 | Read port 0 data |
| rd1_dbl | input | 1 | Read port 1 view: 0 narrow, 1 wide |
| rd1_idx | input | 5 | Read port 1 register index |
| rd1_data | output | 64 | Read port 1 data |
| wr_en | input | 1 | Main write enable |
| wr_dbl | input | 1 | Main write view: 0 narrow, 1 wide |
| wr_idx | input | 5 | Main write register index |
| wr_data | input | 64 | Main write data |
| xfer_wr_en | input | 1 | Transfer write enable |
| xfer_wr_idx | input | 5 | Transfer write narrow index |
| xfer_wr_data | input | 32 | Transfer write data from the integer core |
| xfer_rd_idx | input | 5 | Transfer read narrow index |
| xfer_rd_data | output | 32 | Transfer read data to the integer core |

## Verification
Every read output depends on its index and view inputs and on the stored state with no register in between. The bench therefore samples each read 1 ns after driving it, in the same cycle. A write becomes visible only in the cycle after its rising edge, through either view. The bench drives inputs just after the falling edge and compares all three read outputs with its behavioural model before the next rising edge. It applies the model's writes after that edge, with the transfer write first and the main write second. A read aimed at a register being written in the same cycle is therefore checked against the old contents.

// File: rtl/fpr_alias_pkg.sv
package fpr_alias_pkg;
   typedef enum logic {
      VIEW_NARROW = 1'b0,
      VIEW_WIDE   = 1'b1
   } fpr_view_e;
endpackage

// File: rtl/fpr_wr_decode.sv
module fpr_wr_decode #(
   parameter int SGL_W   = 32,
   parameter int NUM_SGL = 32,
   localparam int DBL_W  = 2 * SGL_W,
   localparam int SIDX_W = $clog2(NUM_SGL)
) (
   input  logic                     wr_en,
   input  logic                     wr_dbl,
   input  logic [SIDX_W-1:0]        wr_idx,
   input  logic [DBL_W-1:0]         wr_data,
   input  logic                     xfer_wr_en,
   input  logic [SIDX_W-1:0]        xfer_wr_idx,
   input  logic [SGL_W-1:0]         xfer_wr_data,
   output logic [NUM_SGL-1:0]       upd,
   output logic [NUM_SGL*SGL_W-1:0] upd_data_flat
);
   import fpr_alias_pkg::*;

   fpr_view_e wr_view;
   assign wr_view = fpr_view_e'(wr_dbl);

   for (genvar i = 0; i < NUM_SGL; i++) begin : g_slot
      localparam logic [SIDX_W-1:0] SLOT = SIDX_W'(i);
      localparam bit                ODD  = (i % 2) == 1;
      logic             main_hit;
      logic             xfer_hit;
      logic [SGL_W-1:0] main_word;

      always_comb begin
         if (wr_view == VIEW_WIDE)
            main_hit = wr_en && (wr_idx[SIDX_W-2:0] == SLOT[SIDX_W-1:1]);
         else
            main_hit = wr_en && (wr_idx == SLOT);
      end

      if (ODD) begin : g_odd
         assign main_word = (wr_view == VIEW_WIDE) ? wr_data[DBL_W-1:SGL_W]
                                                   : wr_data[SGL_W-1:0];
      end else begin : g_even
         assign main_word = wr_data[SGL_W-1:0];
      end

      assign xfer_hit = xfer_wr_en && (xfer_wr_idx == SLOT);
      assign upd[i]   = main_hit || xfer_hit;
      assign upd_data_flat[i*SGL_W +: SGL_W] = main_hit ? main_word : xfer_wr_data;
   end
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank #(
   parameter int SGL_W   = 32,
   parameter int NUM_SGL = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SGL-1:0]       upd,
   input  logic [NUM_SGL*SGL_W-1:0] upd_data_flat,
   output logic [NUM_SGL*SGL_W-1:0] stor_flat
);
   for (genvar i = 0; i < NUM_SGL; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stor_flat[i*SGL_W +: SGL_W] <= '0;
         else if (upd[i])
            stor_flat[i*SGL_W +: SGL_W] <= upd_data_flat[i*SGL_W +: SGL_W];
      end
   end
endmodule

// File: rtl/fpr_read_mux.sv
module fpr_read_mux #(
   parameter int SGL_W   = 32,
   parameter int NUM_SGL = 32,
   parameter int OUT_W   = 64,
   localparam int SIDX_W = $clog2(NUM_SGL)
) (
   input  logic                     view_dbl,
   input  logic [SIDX_W-1:0]        idx,
   input  logic [NUM_SGL*SGL_W-1:0] stor_flat,
   output logic [OUT_W-1:0]         data
);
   import fpr_alias_pkg::*;

   logic [SIDX_W-1:0] lo_slot;
   logic [SIDX_W-1:0] hi_slot;
   assign lo_slot = {idx[SIDX_W-2:0], 1'b0};
   assign hi_slot = {idx[SIDX_W-2:0], 1'b1};

   if (OUT_W == 2 * SGL_W) begin : g_dual_view
      always_comb begin
         if (fpr_view_e'(view_dbl) == VIEW_WIDE)
            data = {stor_flat[hi_slot*SGL_W +: SGL_W], stor_flat[lo_slot*SGL_W +: SGL_W]};
         else
            data = {{SGL_W{1'b0}}, stor_flat[idx*SGL_W +: SGL_W]};
      end
   end else begin : g_narrow_only
      logic unused_view;
      logic [2*SIDX_W-1:0] unused_slots;
      assign unused_view  = view_dbl;
      assign unused_slots = {lo_slot, hi_slot};
      assign data = stor_flat[idx*SGL_W +: SGL_W];
   end
endmodule

// File: rtl/fpr_alias_regfile.sv
module fpr_alias_regfile #(
   parameter int SGL_W   = 32,
   parameter int NUM_SGL = 32,
   localparam int DBL_W  = 2 * SGL_W,
   localparam int SIDX_W = $clog2(NUM_SGL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd0_dbl,
   input  logic [SIDX_W-1:0] rd0_idx,
   output logic [DBL_W-1:0]  rd0_data,
   input  logic              rd1_dbl,
   input  logic [SIDX_W-1:0] rd1_idx,
   output logic [DBL_W-1:0]  rd1_data,
   input  logic              wr_en,
   input  logic              wr_dbl,
   input  logic [SIDX_W-1:0] wr_idx,
   input  logic [DBL_W-1:0]  wr_data,
   input  logic              xfer_wr_en,
   input  logic [SIDX_W-1:0] xfer_wr_idx,
   input  logic [SGL_W-1:0]  xfer_wr_data,
   input  logic [SIDX_W-1:0] xfer_rd_idx,
   output logic [SGL_W-1:0]  xfer_rd_data
);
   if (NUM_SGL < 4 || (NUM_SGL & (NUM_SGL - 1)) != 0) begin : g_bad_depth
      $error("fpr_alias_regfile: NUM_SGL must be a power of two, at least 4");
   end
   if (SGL_W < 1) begin : g_bad_width
      $error("fpr_alias_regfile: SGL_W must be positive");
   end

   logic [NUM_SGL-1:0]       upd;
   logic [NUM_SGL*SGL_W-1:0] upd_data_flat;
   logic [NUM_SGL*SGL_W-1:0] stor_flat;

   fpr_wr_decode #(.SGL_W(SGL_W), .NUM_SGL(NUM_SGL)) u_dec (
      .wr_en        (wr_en),
      .wr_dbl       (wr_dbl),
      .wr_idx       (wr_idx),
      .wr_data      (wr_data),
      .xfer_wr_en   (xfer_wr_en),
      .xfer_wr_idx  (xfer_wr_idx),
      .xfer_wr_data (xfer_wr_data),
      .upd          (upd),
      .upd_data_flat(upd_data_flat)
   );

   fpr_bank #(.SGL_W(SGL_W), .NUM_SGL(NUM_SGL)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .upd          (upd),
      .upd_data_flat(upd_data_flat),
      .stor_flat    (stor_flat)
   );

   fpr_read_mux #(.SGL_W(SGL_W), .NUM_SGL(NUM_SGL), .OUT_W(DBL_W)) u_rd0 (
      .view_dbl (rd0_dbl),
      .idx      (rd0_idx),
      .stor_flat(stor_flat),
      .data     (rd0_data)
   );

   fpr_read_mux #(.SGL_W(SGL_W), .NUM_SGL(NUM_SGL), .OUT_W(DBL_W)) u_rd1 (
      .view_dbl (rd1_dbl),
      .idx      (rd1_idx),
      .stor_flat(stor_flat),
      .data     (rd1_data)
   );

   fpr_read_mux #(.SGL_W(SGL_W), .NUM_SGL(NUM_SGL), .OUT_W(SGL_W)) u_xrd (
      .view_dbl (1'b0),
      .idx      (xfer_rd_idx),
      .stor_flat(stor_flat),
      .data     (xfer_rd_data)
   );
endmodule

// File: rtl/fpr_alias_chk.sv
module fpr_alias_chk #(
   parameter int SGL_W   = 32,
   parameter int NUM_SGL = 32,
   localparam int DBL_W  = 2 * SGL_W,
   localparam int SIDX_W = $clog2(NUM_SGL)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic                     wr_dbl,
   input logic [SIDX_W-1:0]        wr_idx,
   input logic [DBL_W-1:0]         wr_data,
   input logic                     xfer_wr_en,
   input logic [SIDX_W-1:0]        xfer_wr_idx,
   input logic                     rd0_dbl,
   input logic [DBL_W-1:0]         rd0_data,
   input logic [NUM_SGL*SGL_W-1:0] stor_flat
);
   localparam logic [SIDX_W-1:0] ONE = SIDX_W'(1);

   function automatic logic [SGL_W-1:0] word_at(input logic [SIDX_W-1:0] k);
      return stor_flat[k*SGL_W +: SGL_W];
   endfunction

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> stor_flat == '0);

   // R4
   wide_write_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_dbl |=>
         word_at({$past(wr_idx[SIDX_W-2:0]), 1'b0}) == $past(wr_data[SGL_W-1:0]));

   // R4
   wide_write_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_dbl |=>
         word_at({$past(wr_idx[SIDX_W-2:0]), 1'b1}) == $past(wr_data[DBL_W-1:SGL_W]));

   // R5
   narrow_partner_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_dbl && !(xfer_wr_en && xfer_wr_idx == (wr_idx ^ ONE)) |=>
         word_at($past(wr_idx) ^ ONE) == $past(word_at(wr_idx ^ ONE)));

   // R8
   main_beats_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_dbl && xfer_wr_en && xfer_wr_idx == wr_idx |=>
         word_at($past(wr_idx)) == $past(wr_data[SGL_W-1:0]));

   // R2
   narrow_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd0_dbl |-> rd0_data[DBL_W-1:SGL_W] == '0);
endmodule

bind fpr_alias_regfile fpr_alias_chk #(.SGL_W(SGL_W), .NUM_SGL(NUM_SGL)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_dbl     (wr_dbl),
   .wr_idx     (wr_idx),
   .wr_data    (wr_data),
   .xfer_wr_en (xfer_wr_en),
   .xfer_wr_idx(xfer_wr_idx),
   .rd0_dbl    (rd0_dbl),
   .rd0_data   (rd0_data),
   .stor_flat  (stor_flat)
);

// File: tb/test_fpr_alias_regfile.sv
`timescale 1ns/1ps
module test_fpr_alias_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd0_dbl = 1'b0, rd1_dbl = 1'b0;
   logic [4:0]  rd0_idx = '0, rd1_idx = '0;
   logic [63:0] rd0_data, rd1_data;
   logic        wr_en = 1'b0, wr_dbl = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [63:0] wr_data = '0;
   logic        xfer_wr_en = 1'b0;
   logic [4:0]  xfer_wr_idx = '0, xfer_rd_idx = '0;
   logic [31:0] xfer_wr_data = '0;
   logic [31:0] xfer_rd_data;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [31:0] model [32];

   always #2 clk = ~clk;

   fpr_alias_regfile i_fpr_alias_regfile (
      .clk(clk), .rst_n(rst_n),
      .rd0_dbl(rd0_dbl), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
      .rd1_dbl(rd1_dbl), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
      .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_idx(wr_idx), .wr_data(wr_data),
      .xfer_wr_en(xfer_wr_en), .xfer_wr_idx(xfer_wr_idx), .xfer_wr_data(xfer_wr_data),
      .xfer_rd_idx(xfer_rd_idx), .xfer_rd_data(xfer_rd_data)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [63:0] expect_read(input logic dbl, input logic [4:0] idx);
      int n;
      if (dbl) begin
         n = int'(idx) % 16;
         return {model[2*n+1], model[2*n]};
      end
      return {32'h0, model[int'(idx)]};
   endfunction

   // Compare reads in this cycle, then let the edge happen and update the model.
   task automatic tick();
      #1;
      chk(rd0_dbl ? "R3 rd0" : "R2 rd0", rd0_data, expect_read(rd0_dbl, rd0_idx));
      chk(rd1_dbl ? "R3 rd1" : "R2 rd1", rd1_data, expect_read(rd1_dbl, rd1_idx));
      chk("R7 xfer_rd", {32'h0, xfer_rd_data}, {32'h0, model[int'(xfer_rd_idx)]});
      @(posedge clk);
      if (xfer_wr_en) model[int'(xfer_wr_idx)] = xfer_wr_data;
      if (wr_en) begin
         if (wr_dbl) begin
            model[2*(int'(wr_idx) % 16)]     = wr_data[31:0];
            model[2*(int'(wr_idx) % 16) + 1] = wr_data[63:32];
         end else begin
            model[int'(wr_idx)] = wr_data[31:0];
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
      xfer_wr_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 32; k++) model[k] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: everything zero after reset
      for (int k = 0; k < 32; k++) begin
         xfer_rd_idx = 5'(k);
         #1 chk("R1 reset narrow", {32'h0, xfer_rd_data}, 64'h0);
      end
      rd0_dbl = 1'b1; rd0_idx = 5'd15;
      #1 chk("R1 reset wide", rd0_data, 64'h0);
      @(negedge clk);

      // R4 / R10: wide write to pair 3 with index bit 4 set
      wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'b10011; wr_data = 64'h1111_2222_3333_4444;
      tick();
      xfer_rd_idx = 5'd6; rd0_dbl = 1'b0; rd0_idx = 5'd7; rd1_dbl = 1'b1; rd1_idx = 5'd3;
      #1;
      chk("R4 low half to even", {32'h0, xfer_rd_data}, 64'h3333_4444);
      chk("R4 high half to odd", rd0_data, 64'h1111_2222);
      chk("R10 wide read of pair 3", rd1_data, 64'h1111_2222_3333_4444);
      rd1_idx = 5'd19;
      #1 chk("R3 index bit 4 ignored on read", rd1_data, 64'h1111_2222_3333_4444);
      xfer_rd_idx = 5'd22;
      #1 chk("R10 pair 11 untouched", {32'h0, xfer_rd_data}, 64'h0);
      tick();

      // R5: narrow write to odd half, upper data ignored, partner kept
      wr_en = 1'b1; wr_dbl = 1'b0; wr_idx = 5'd7; wr_data = 64'hABCD_0000_DEAD_BEEF;
      tick();
      rd0_dbl = 1'b1; rd0_idx = 5'd3;
      #1 chk("R5 narrow write seen in wide view", rd0_data, 64'hDEAD_BEEF_3333_4444);
      tick();

      // R9: same-cycle read returns old value
      wr_en = 1'b1; wr_dbl = 1'b0; wr_idx = 5'd10; wr_data = 64'h0000_0000_5555_AAAA;
      rd0_dbl = 1'b0; rd0_idx = 5'd10;
      #1 chk("R9 no bypass", rd0_data, 64'h0);
      tick();
      #1 chk("R9 new value after edge", rd0_data, 64'h5555_AAAA);

      // R6: transfer write
      xfer_wr_en = 1'b1; xfer_wr_idx = 5'd20; xfer_wr_data = 32'h0000_CAFE;
      tick();
      rd0_dbl = 1'b1; rd0_idx = 5'd10;
      #1 chk("R6 transfer write", rd0_data, 64'h0000_0000_0000_CAFE);

      // R8: collision on S23 (main wide to pair 11), and non-overlapping pair
      wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'd11; wr_data = 64'h8888_9999_6666_7777;
      xfer_wr_en = 1'b1; xfer_wr_idx = 5'd23; xfer_wr_data = 32'h0000_0077;
      tick();
      xfer_rd_idx = 5'd23;
      #1 chk("R8 main wins on overlap", {32'h0, xfer_rd_data}, 64'h8888_9999);
      wr_en = 1'b1; wr_dbl = 1'b0; wr_idx = 5'd1; wr_data = 64'h0000_0000_0101_0101;
      xfer_wr_en = 1'b1; xfer_wr_idx = 5'd2; xfer_wr_data = 32'h0202_0202;
      tick();
      rd0_dbl = 1'b0; rd0_idx = 5'd1; xfer_rd_idx = 5'd2;
      #1;
      chk("R8 main applied alongside transfer", rd0_data, 64'h0101_0101);
      chk("R8 transfer applied alongside main", {32'h0, xfer_rd_data}, 64'h0202_0202);

      // Random traffic against the model (R2 R3 R4 R5 R6 R7 R8 R9)
      for (int c = 0; c < 3000; c++) begin
         wr_en        = ($urandom_range(0, 3) != 0);
         wr_dbl       = 1'($urandom_range(0, 1));
         wr_idx       = 5'($urandom_range(0, 31));
         wr_data      = {$urandom, $urandom};
         xfer_wr_en   = ($urandom_range(0, 2) == 0);
         xfer_wr_idx  = ($urandom_range(0, 3) == 0) ? wr_idx : 5'($urandom_range(0, 31));
         xfer_wr_data = $urandom;
         rd0_dbl      = 1'($urandom_range(0, 1));
         rd0_idx      = ($urandom_range(0, 3) == 0) ? wr_idx : 5'($urandom_range(0, 31));
         rd1_dbl      = 1'($urandom_range(0, 1));
         rd1_idx      = 5'($urandom_range(0, 31));
         xfer_rd_idx  = 5'($urandom_range(0, 31));
         tick();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule